// File: doc/BRIEF.md
# Byte-Serial DMA Address and Direction Register

This block sits in a bus bridge that serves a single SCSI protocol chip. A host with an 8-bit data bus programs a 32-bit control word into it, one byte per write. The top bit of that word chooses the transfer direction. The remaining 31 bits hold a halfword index, which is the word-aligned memory byte address shifted right by one. The block assembles the word and presents the direction and the index to a downstream DMA engine. A one-cycle strobe marks the moment a complete word has been taken.

Two register offsets are decoded. The host first writes the top byte of the word to an arming register. It then writes the bytes to a single address port, most significant first.

A parameter picks one of two variants:
- **Full variant:** the arming register sits at offset 0x8000. Four bytes go to the address port.
- **Reduced variant:** the arming register sits at offset 0x10. Three bytes go to the address port, and the top byte is taken from the arming register.

While a transfer runs, each pulse of the word-completion input advances the index by one, which moves the byte address on by two. The block holds no data buffer. The byte count of a transfer therefore equals the count held in the SCSI chip's FIFO, and one transfer is limited to 0x1000000 bytes by that chip's 24-bit length. The host port is a plain register-write interface with no back-pressure: every write is taken in the cycle it is presented.

Top module: `dma_addr_reg`

## Requirements
- R1: After reset, load_valid is 0, to_mem is 0, hw_index is 0 and mem_byte_addr is 0.
- R2: A host write is decoded by host_addr as follows:
  - offset 0 is the address port;
  - offset 0x8000 (full variant) or 0x10 (reduced variant) is the arming register;
  - a write to any other offset changes no output and does not advance a load sequence.
- R3: Full variant: after an arming write, four address-port writes carrying bits 31..24, 23..16, 15..8 and 7..0 form the control word. The arming byte is not part of the word. The clock edge that takes the fourth byte sets to_mem to bit 31 and hw_index to bits 30..0, and raises load_valid for exactly one cycle.
- R4: Reduced variant: after an arming write, three address-port writes carrying bits 23..16, 15..8 and 7..0 complete the word, and bits 31..24 are the arming byte. The edge that takes the third byte updates to_mem and hw_index together and pulses load_valid for one cycle.
- R5: An arming write in the middle of a sequence drops the bytes taken so far and produces no load_valid pulse. A following full sequence loads normally.
- R6: An address-port write that is not preceded by an arming write is ignored, and so is any address-port write after a completed load until the next arming write. An ignored write changes no output and produces no load_valid.
- R7: A word_done pulse increments hw_index by one, wrapping from 0x7FFFFFFF to 0. to_mem is unchanged.
- R8: If word_done coincides with the write that completes a load, the loaded word is taken and the increment is discarded.
- R9: to_mem and hw_index change only on a completed load or on word_done.
- R10: mem_byte_addr always equals hw_index shifted left by one, with bit 0 equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe |
| host_addr | input | HOST_AW | Host register offset |
| host_wdata | input | 8 | Host write byte |
| word_done | input | 1 | One 16-bit word moved by the DMA engine |
| load_valid | output | 1 | One-cycle strobe: new control word taken |
| to_mem | output | 1 | Direction, 1 = toward memory |
| hw_index | output | 31 | Halfword index of the current address |
| mem_byte_addr | output | 32 | Byte address (index shifted left by one) |

## Verification
Two functions can act in the same cycle: completing a load and stepping the address with word_done. The bench provokes this by raising word_done during the final address-port byte, in both variants. The bench then requires the exact loaded word with no increment applied, which R8 defines. It also steps the index across its wrap point, and it interleaves stray-offset writes and aborted sequences with full loads. The expected index is computed arithmetically each time.

// File: rtl/dar_pkg.sv
package dar_pkg;
  typedef enum logic [1:0] {
    HOST_NONE  = 2'd0,
    HOST_LATCH = 2'd1,
    HOST_ADDR  = 2'd2
  } host_op_e;

  typedef struct packed {
    logic        to_mem;
    logic [30:0] hw_index;
  } dma_ctrl_t;
endpackage

// File: rtl/dar_decode.sv
module dar_decode
  import dar_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [AW-1:0] LATCH_OFS = '0
) (
  input  logic          host_wr,
  input  logic [AW-1:0] host_addr,
  output host_op_e      op
);
  always_comb begin
    op = HOST_NONE;
    if (host_wr) begin
      if (host_addr == LATCH_OFS)   op = HOST_LATCH;
      else if (host_addr == '0)     op = HOST_ADDR;
    end
  end
endmodule

// File: rtl/dar_sequencer.sv
module dar_sequencer
  import dar_pkg::*;
#(
  parameter bit FULL = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  host_op_e  op,
  input  logic [7:0] wdata,
  output logic      commit,
  output dma_ctrl_t new_ctrl,
  output logic      load_valid
);
  localparam int NBYTES = FULL ? 4 : 3;
  localparam logic [1:0] LAST = 2'(NBYTES - 1);

  logic [7:0]  latch_q;
  logic [23:0] asm_q;
  logic [1:0]  cnt_q;
  logic        armed_q;
  logic [31:0] word;

  assign commit = (op == HOST_ADDR) && armed_q && (cnt_q == LAST);

  generate
    if (FULL) begin : g_full
      assign word = {asm_q, wdata};
    end else begin : g_reduced
      assign word = {latch_q, asm_q[15:0], wdata};
    end
  endgenerate

  assign new_ctrl = dma_ctrl_t'(word);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      latch_q    <= '0;
      asm_q      <= '0;
      cnt_q      <= '0;
      armed_q    <= 1'b0;
      load_valid <= 1'b0;
    end else begin
      load_valid <= commit;
      if (op == HOST_LATCH) begin
        latch_q <= wdata;
        asm_q   <= '0;
        cnt_q   <= '0;
        armed_q <= 1'b1;
      end else if (op == HOST_ADDR && armed_q) begin
        if (commit) begin
          armed_q <= 1'b0;
          cnt_q   <= '0;
        end else begin
          asm_q <= {asm_q[15:0], wdata};
          cnt_q <= cnt_q + 2'd1;
        end
      end
    end
  end

  assert_lv_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |=> !load_valid);
  assert_abort_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == HOST_LATCH) |=> !load_valid);
  assert_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == HOST_ADDR && !armed_q) |=> !load_valid);
  assert_cnt_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/dar_counter.sv
module dar_counter
  import dar_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load,
  input  dma_ctrl_t load_ctrl,
  input  logic      step,
  output dma_ctrl_t ctrl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
    end else if (load) begin
      ctrl <= load_ctrl;
    end else if (step) begin
      ctrl.hw_index <= ctrl.hw_index + 31'd1;
    end
  end

  assert_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ctrl.hw_index == $past(ctrl.hw_index) + 31'd1)
                        && (ctrl.to_mem == $past(ctrl.to_mem)));
  assert_load_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ctrl == $past(load_ctrl));
  assert_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(ctrl));
endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dar_pkg::*;
#(
  parameter bit FULL_VARIANT = 1'b1,
  parameter int HOST_AW      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [HOST_AW-1:0] host_addr,
  input  logic [7:0]         host_wdata,
  input  logic               word_done,
  output logic               load_valid,
  output logic               to_mem,
  output logic [30:0]        hw_index,
  output logic [31:0]        mem_byte_addr
);
  localparam logic [HOST_AW-1:0] LATCH_OFS =
    FULL_VARIANT ? HOST_AW'(32'h8000) : HOST_AW'(32'h10);

  host_op_e  op;
  logic      commit;
  dma_ctrl_t new_ctrl;
  dma_ctrl_t ctrl;

  dar_decode #(.AW(HOST_AW), .LATCH_OFS(LATCH_OFS)) u_decode (
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .op       (op)
  );

  dar_sequencer #(.FULL(FULL_VARIANT)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .wdata     (host_wdata),
    .commit    (commit),
    .new_ctrl  (new_ctrl),
    .load_valid(load_valid)
  );

  dar_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (commit),
    .load_ctrl(new_ctrl),
    .step     (word_done),
    .ctrl     (ctrl)
  );

  assign to_mem        = ctrl.to_mem;
  assign hw_index      = ctrl.hw_index;
  assign mem_byte_addr = {ctrl.hw_index, 1'b0};

  assert_lv_matches_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_valid |-> $past(host_wr) && ($past(host_addr) == '0));
  assert_byte_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_byte_addr[0] == 1'b0);
endmodule

// File: tb/dma_addr_reg_tb.sv
module dma_addr_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_f = 1'b0, wr_r = 1'b0, wd_f = 1'b0, wd_r = 1'b0;
  logic [15:0] haddr = '0;
  logic [7:0]  hdata = '0;
  logic        lv_f, lv_r, tm_f, tm_r;
  logic [30:0] ix_f, ix_r;
  logic [31:0] ba_f, ba_r;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dma_addr_reg #(.FULL_VARIANT(1'b1), .HOST_AW(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(wr_f), .host_addr(haddr),
    .host_wdata(hdata), .word_done(wd_f), .load_valid(lv_f),
    .to_mem(tm_f), .hw_index(ix_f), .mem_byte_addr(ba_f));

  dma_addr_reg #(.FULL_VARIANT(1'b0), .HOST_AW(16)) u_dut_red (
    .clk(clk), .rst_n(rst_n), .host_wr(wr_r), .host_addr(haddr),
    .host_wdata(hdata), .word_done(wd_r), .load_valid(lv_r),
    .to_mem(tm_r), .hw_index(ix_r), .mem_byte_addr(ba_r));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input bit red, input logic [15:0] a, input logic [7:0] d, input bit wd = 1'b0);
    @(negedge clk);
    haddr = a; hdata = d;
    if (red) begin wr_r = 1'b1; wd_r = wd; end
    else     begin wr_f = 1'b1; wd_f = wd; end
    @(negedge clk);
    wr_f = 1'b0; wr_r = 1'b0; wd_f = 1'b0; wd_r = 1'b0;
  endtask

  function automatic logic [15:0] latch_ofs(input bit red);
    return red ? 16'h0010 : 16'h8000;
  endfunction

  // full load; final byte optionally with word_done; checks the result
  task automatic load(input bit red, input logic [31:0] w, input bit wd_last, input string req);
    wr(red, latch_ofs(red), red ? w[31:24] : (w[31:24] ^ 8'h5A));
    if (!red) wr(0, 16'h0000, w[31:24]);
    wr(red, 16'h0000, w[23:16]);
    wr(red, 16'h0000, w[15:8]);
    wr(red, 16'h0000, w[7:0], wd_last);
    check({req, " load_valid"}, red ? lv_r : lv_f, 1);
    check({req, " to_mem"}, red ? tm_r : tm_f, w[31]);
    check({req, " hw_index"}, red ? ix_r : ix_f, {1'b0, w[30:0]});
    check({"R10 byte addr"}, red ? ba_r : ba_f, {w[30:0], 1'b0});
    @(negedge clk);
    check({req, " pulse width"}, red ? lv_r : lv_f, 0);
  endtask

  task automatic steps(input bit red, input int n);
    @(negedge clk);
    if (red) wd_r = 1'b1; else wd_f = 1'b1;
    repeat (n) @(negedge clk);
    wd_f = 1'b0; wd_r = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 lv_f", lv_f, 0); check("R1 lv_r", lv_r, 0);
    check("R1 ix_f", ix_f, 0); check("R1 tm_f", tm_f, 0);
    check("R1 ba_r", ba_r, 0);
    rst_n = 1'b1;
    // R6 address writes before any arming write
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 5; k++) wr(b[0], 16'h0000, 8'hFF);
      check("R6 unarmed lv", b[0] ? lv_r : lv_f, 0);
      check("R6 unarmed index", b[0] ? ix_r : ix_f, 0);
      check("R6 unarmed dir", b[0] ? tm_r : tm_f, 0);
    end
    // R3 / R4 sweep of many words, both variants
    for (int i = 0; i < 120; i++) begin
      logic [31:0] w;
      w = (i * 32'h9E3779B1) ^ (i << 7);
      load(0, w, 0, "R3");
      load(1, w, 0, "R4");
      // R6 extra write after completion is ignored
      wr(0, 16'h0000, 8'hA5); wr(1, 16'h0000, 8'hA5);
      check("R6 post-load lv_f", lv_f, 0);
      check("R6 post-load ix_f", ix_f, {1'b0, w[30:0]});
      check("R6 post-load ix_r", ix_r, {1'b0, w[30:0]});
      check("R9 post-load tm_r", tm_r, w[31]);
    end
    // R5 abort at every position, R2 stray offsets inside a sequence
    for (int b = 0; b < 2; b++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] w;
        w = 32'h8123_4567 + k * 32'h0101_0101;
        if (b == 1 && k == 3) continue;
        wr(b[0], latch_ofs(b[0]), 8'h77);
        for (int j = 0; j < k; j++) begin
          wr(b[0], 16'h0000, 8'h3C);
          check("R5 partial lv", b[0] ? lv_r : lv_f, 0);
        end
        wr(b[0], latch_ofs(b[0]), 8'h11);
        check("R5 abort lv", b[0] ? lv_r : lv_f, 0);
        // restart, with stray offsets interleaved
        wr(b[0], latch_ofs(b[0]), b[0] ? w[31:24] : 8'h00);
        wr(b[0], 16'h0004, 8'hEE);
        wr(b[0], b[0] ? 16'h8000 : 16'h0010, 8'hDD);
        check("R2 stray lv", b[0] ? lv_r : lv_f, 0);
        if (b == 0) wr(0, 16'h0000, w[31:24]);
        wr(b[0], 16'h0000, w[23:16]);
        wr(b[0], 16'h0001, 8'hCC);
        wr(b[0], 16'h0000, w[15:8]);
        wr(b[0], 16'h0000, w[7:0]);
        check("R2/R5 reload lv", b[0] ? lv_r : lv_f, 1);
        check("R2/R5 reload index", b[0] ? ix_r : ix_f, {1'b0, w[30:0]});
        check("R2/R5 reload dir", b[0] ? tm_r : tm_f, w[31]);
      end
    end
    // R7 stepping, several counts
    for (int n = 1; n < 40; n += 7) begin
      logic [31:0] w;
      w = 32'h0000_1000 * n + 32'h8000_0003;
      load(0, w, 0, "R3");
      steps(0, n);
      check("R7 step index", ix_f, {1'b0, w[30:0] + 31'(n)});
      check("R7 step dir", tm_f, w[31]);
      check("R10 step byte addr", ba_f, {w[30:0] + 31'(n), 1'b0});
      repeat (3) @(negedge clk);
      check("R9 idle stable", ix_f, {1'b0, w[30:0] + 31'(n)});
    end
    // R7 wrap
    load(1, 32'hFFFF_FFFE, 0, "R4");
    steps(1, 2);
    check("R7 wrap index", ix_r, 0);
    check("R7 wrap dir", tm_r, 1);
    // R8 collision of load and step, both variants
    for (int b = 0; b < 2; b++) begin
      load(b[0], 32'h0000_0010, 0, "R8 pre");
      load(b[0], 32'h4000_0200 + b, 1, "R8 collide");
    end
    done = 1'b1;
    finish_run();
  end
endmodule